// File: doc/BRIEF.md
# Parity-Code Concurrent Error Checker

This block sits beside a combinational function whose M result bits must be watched while it runs. A second, independent copy of that logic (the predictor) supplies K predicted check bits for each result word. The checker recomputes the check bits from the observed result bits under one of three codes, XORs them with the predicted bits into a K-bit syndrome, and raises an error flag when any syndrome bit is set. It never alters or corrects the result bits: one fault inside the function can disturb several result bits together, so a correction step would only produce wrong data.

The code is picked by a parameter. Single parity uses one check bit. Split parity uses two check bits, one for each half of an interleaved split of the result bits. The weighted code uses K check bits and one coefficient row per result bit. The rows come from the list of all K-bit values holding two or more ones, in ascending order, reordered so that the rows do not cluster. The rows are built at elaboration time, and elaboration stops with an error when M exceeds the number of rows K bits can supply, or when K does not match the chosen code. The result can be registered (one cycle of latency) or passed straight through.

Top module: `ced_checker`

## Requirements
- R1: With MODE=0 and K=1, syndrome bit 0 is the XOR of all M data bits and predicted bit 0, so a flip of an even number of data bits is not flagged.
- R2: With MODE=1 and K=2, syndrome bit 0 covers the data bits at even positions (0, 2, 4, ...) and syndrome bit 1 covers the data bits at odd positions, each XORed with the predicted bit of the same index.
- R3: With MODE=2, syndrome bit j is the XOR of every data bit i whose coefficient row has bit j set (bit 0 is the least significant bit of the row), XORed with predicted bit j.
- R4: Coefficient rows are the K-bit values with at least two ones in ascending order, numbered 1..N; position p takes the value at position N+1-p whenever p or N+1-p is even, otherwise its own value; data bit i uses position i+1. For K=4 the first seven rows are 3, E, 6, C, 9, A, B (hex).
- R5: The error flag is high exactly when at least one syndrome bit is set.
- R6: With REG_OUT=1 the syndrome and flag reflect the inputs sampled at the previous rising clock edge and hold while the inputs hold; with REG_OUT=0 they follow the inputs in the same cycle.
- R7: With REG_OUT=1 a synchronous active-high reset clears the syndrome and the flag at the next rising edge, whatever the inputs.
- R8: In every mode, flipping any single data bit of a word whose predicted bits are correct raises the error flag.
- R9: Flipping one predicted bit while the data is unchanged flips exactly the syndrome bit of the same index.
- R10: With MODE=2, flipping any two distinct data bits of a correctly predicted word raises the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| data_i | input | M | Result bits of the watched function |
| pred_i | input | K | Check bits from the duplicated predictor |
| syndrome_o | output | K | Recomputed check bits XOR predicted check bits |
| err_o | output | 1 | High when the syndrome is non-zero |

## Verification
The bound checker watches, on every cycle, that the flag agrees with the syndrome, that the registered outputs hold while the inputs hold and clear after reset, that a one-bit change of the data always moves the syndrome, and that a one-bit change of a predicted bit moves exactly one syndrome bit. The exact coefficient rows, the interleaving of the split-parity groups, the blindness of single parity to even-weight flips and the full coverage of two-bit flips by the weighted code are properties of the values, not of the cycle relations, and only the bench's table, row probes and corruption sweeps over valid base words show them, together with the fraction of corrupted words each code flags.

// File: rtl/ced_pkg.sv
package ced_pkg;

  localparam int MODE_PARITY = 0;
  localparam int MODE_SPLIT  = 1;
  localparam int MODE_WEIGHT = 2;
  localparam int ROW_W_MAX   = 8;

  // number of K-bit values carrying two or more ones
  function automatic int heavy_count(input int k);
    return (1 << k) - 1 - k;
  endfunction

  // n-th (0-based) K-bit value with two or more ones, ascending
  function automatic logic [ROW_W_MAX-1:0] heavy_value(input int k, input int n);
    int seen;
    logic [ROW_W_MAX-1:0] found;
    seen  = 0;
    found = '0;
    for (int v = 0; v < (1 << k); v++) begin
      if ($countones(v) >= 2) begin
        if (seen == n) found = ROW_W_MAX'(v);
        seen++;
      end
    end
    return found;
  endfunction

  // coefficient row for data bit idx after the front/back reordering
  function automatic logic [ROW_W_MAX-1:0] coef_row(input int k, input int idx);
    int total;
    int pos;
    int mirror;
    int src;
    total  = heavy_count(k);
    pos    = idx + 1;
    mirror = total + 1 - pos;
    if ((pos % 2 == 0) || (mirror % 2 == 0)) src = mirror;
    else src = pos;
    return heavy_value(k, src - 1);
  endfunction

endpackage

// File: rtl/ced_checkbit_gen.sv
module ced_checkbit_gen #(
  parameter int M    = 7,
  parameter int K    = 4,
  parameter int MODE = 2
) (
  input  logic [M-1:0] data_i,
  output logic [K-1:0] calc_o
);

  generate
    if (MODE == ced_pkg::MODE_PARITY) begin : g_parity
      assign calc_o = K'(^data_i);
    end else if (MODE == ced_pkg::MODE_SPLIT) begin : g_split
      always_comb begin
        calc_o = '0;
        for (int i = 0; i < M; i++) begin
          calc_o[i % 2] = calc_o[i % 2] ^ data_i[i];
        end
      end
    end else begin : g_weight
      logic [K-1:0] contrib [M];
      for (genvar i = 0; i < M; i++) begin : g_row
        localparam logic [ced_pkg::ROW_W_MAX-1:0] ROW_FULL = ced_pkg::coef_row(K, i);
        localparam logic [K-1:0] ROW = ROW_FULL[K-1:0];
        assign contrib[i] = {K{data_i[i]}} & ROW;
      end
      always_comb begin
        calc_o = '0;
        for (int i = 0; i < M; i++) begin
          calc_o = calc_o ^ contrib[i];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ced_syndrome_cmp.sv
module ced_syndrome_cmp #(
  parameter int K = 4
) (
  input  logic [K-1:0] calc_i,
  input  logic [K-1:0] pred_i,
  output logic [K-1:0] syndrome_o,
  output logic         err_o
);

  assign syndrome_o = calc_i ^ pred_i;
  assign err_o      = |(calc_i ^ pred_i);

endmodule

// File: rtl/ced_out_stage.sv
module ced_out_stage #(
  parameter int W       = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
      end
    end else begin : g_wire
      assign q_o = d_i;
    end
  endgenerate

endmodule

// File: rtl/ced_checker.sv
module ced_checker #(
  parameter int M       = 7,
  parameter int K       = 4,
  parameter int MODE    = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] data_i,
  input  logic [K-1:0] pred_i,
  output logic [K-1:0] syndrome_o,
  output logic         err_o
);

  localparam int OUT_W = K + 1;

  generate
    if (M < 1 || M > 32) begin : g_bad_m
      $error("ced_checker: M must lie in 1..32");
    end
    if (MODE == ced_pkg::MODE_PARITY && K != 1) begin : g_bad_par
      $error("ced_checker: single parity needs K=1");
    end
    if (MODE == ced_pkg::MODE_SPLIT && K != 2) begin : g_bad_split
      $error("ced_checker: split parity needs K=2");
    end
    if (MODE == ced_pkg::MODE_WEIGHT) begin : g_chk_weight
      if (K < 3 || K > ced_pkg::ROW_W_MAX) begin : g_bad_k
        $error("ced_checker: weighted code needs K in 3..8");
      end else if (M > ced_pkg::heavy_count(K)) begin : g_bad_rows
        $error("ced_checker: M exceeds the rows available for K");
      end
    end
    if (MODE < 0 || MODE > 2) begin : g_bad_mode
      $error("ced_checker: MODE must be 0, 1 or 2");
    end
  endgenerate

  logic [K-1:0]     calc;
  logic [K-1:0]     syn_c;
  logic             err_c;
  logic [OUT_W-1:0] out_q;

  ced_checkbit_gen #(.M(M), .K(K), .MODE(MODE)) u_gen (
    .data_i (data_i),
    .calc_o (calc)
  );

  ced_syndrome_cmp #(.K(K)) u_cmp (
    .calc_i     (calc),
    .pred_i     (pred_i),
    .syndrome_o (syn_c),
    .err_o      (err_c)
  );

  ced_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
    .clk (clk),
    .rst (rst),
    .d_i ({err_c, syn_c}),
    .q_o (out_q)
  );

  assign syndrome_o = out_q[K-1:0];
  assign err_o      = out_q[K];

endmodule

// File: rtl/ced_checker_sva.sv
module ced_checker_sva #(
  parameter int M       = 7,
  parameter int K       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [M-1:0] data_i,
  input logic [K-1:0] pred_i,
  input logic [K-1:0] syndrome_o,
  input logic         err_o
);

  logic rst_q = 1'b0;
  always @(posedge clk) rst_q <= rst;

  // R5
  always @(posedge clk) begin
    if (!rst) begin
      err_or_chk: assert (err_o == (syndrome_o != '0))
        else $error("flag disagrees with syndrome");
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      // R7
      always @(posedge clk) begin
        if (rst_q) begin
          reset_clear_chk: assert (syndrome_o == '0 && !err_o)
            else $error("outputs not cleared by reset");
        end
      end

      // R6
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $stable(data_i) && $stable(pred_i)) |=> $stable(syndrome_o));

      // R8
      single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $stable(pred_i) && $countones(data_i ^ $past(data_i)) == 1)
        |=> (syndrome_o != $past(syndrome_o)));

      // R9
      pred_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $stable(data_i) && $countones(pred_i ^ $past(pred_i)) == 1)
        |=> ($countones(syndrome_o ^ $past(syndrome_o)) == 1));
    end else begin : g_comb
      // R8
      single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $stable(pred_i) && $countones(data_i ^ $past(data_i)) == 1)
        |-> (syndrome_o != $past(syndrome_o)));

      // R9
      pred_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && $stable(data_i) && $countones(pred_i ^ $past(pred_i)) == 1)
        |-> ($countones(syndrome_o ^ $past(syndrome_o)) == 1));
    end
  endgenerate

endmodule

bind ced_checker ced_checker_sva #(.M(M), .K(K), .REG_OUT(REG_OUT)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .data_i     (data_i),
  .pred_i     (pred_i),
  .syndrome_o (syndrome_o),
  .err_o      (err_o)
);

// File: tb/test_ced_checker.sv
module test_ced_checker;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] data8;
  logic [3:0] pred_h;
  logic [0:0] pred_p;
  logic [1:0] pred_d;
  logic [3:0] syn_h, syn_c;
  logic [0:0] syn_p;
  logic [1:0] syn_d;
  logic       err_h, err_c, err_p, err_d;

  int nchk  = 0;
  int nfail = 0;
  int cyc   = 0;
  int rows [11];

  always #4 clk = ~clk;

  ced_checker #(.M(7), .K(4), .MODE(2), .REG_OUT(1'b1)) i_ced_checker (
    .clk(clk), .rst(rst), .data_i(data8[6:0]), .pred_i(pred_h),
    .syndrome_o(syn_h), .err_o(err_h));

  ced_checker #(.M(7), .K(4), .MODE(2), .REG_OUT(1'b0)) i_ced_comb (
    .clk(clk), .rst(rst), .data_i(data8[6:0]), .pred_i(pred_h),
    .syndrome_o(syn_c), .err_o(err_c));

  ced_checker #(.M(8), .K(1), .MODE(0), .REG_OUT(1'b1)) i_ced_par (
    .clk(clk), .rst(rst), .data_i(data8), .pred_i(pred_p),
    .syndrome_o(syn_p), .err_o(err_p));

  ced_checker #(.M(8), .K(2), .MODE(1), .REG_OUT(1'b1)) i_ced_dbl (
    .clk(clk), .rst(rst), .data_i(data8), .pred_i(pred_d),
    .syndrome_o(syn_d), .err_o(err_d));

  // {data[6:0], pred[3:0], expected syndrome[3:0]}
  localparam logic [14:0] VEC [7] = '{
    {7'h00, 4'h0, 4'h0},
    {7'h01, 4'h0, 4'h3},
    {7'h7F, 4'h0, 4'hF},
    {7'h7F, 4'hF, 4'h0},
    {7'h50, 4'h0, 4'h2},
    {7'h2A, 4'h8, 4'h0},
    {7'h14, 4'h5, 4'hA}
  };
  localparam logic [3:0] ROWTAB [7] = '{4'h3, 4'hE, 4'h6, 4'hC, 4'h9, 4'hA, 4'hB};

  int flag_p = 0, tot_p = 0, flag_d = 0, tot_d = 0, flag_h = 0, tot_h = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ham(input logic [6:0] d);
    logic [3:0] acc = '0;
    for (int i = 0; i < 7; i++) if (d[i]) acc = acc ^ 4'(rows[i]);
    return acc;
  endfunction

  function automatic logic [1:0] dbl(input logic [7:0] d);
    logic [1:0] acc = '0;
    for (int i = 0; i < 8; i += 2) acc[0] = acc[0] ^ d[i];
    for (int i = 1; i < 8; i += 2) acc[1] = acc[1] ^ d[i];
    return acc;
  endfunction

  task automatic set_word(input logic [7:0] base);
    data8  = base;
    pred_h = ham(base[6:0]);
    pred_p = ^base;
    pred_d = dbl(base);
  endtask

  task automatic sweep(input logic [7:0] base);
    set_word(base);
    @(negedge clk);
    chk("R5 valid word flags nothing (weighted)", int'(err_h), 0);
    chk("R5 valid word flags nothing (split)", int'(err_d), 0);
    for (int i = 0; i < 8; i++) begin
      data8 = base ^ (8'h01 << i);
      @(negedge clk);
      chk("R8 single flip, single parity", int'(err_p), 1);
      chk("R8 single flip, split parity", int'(err_d), 1);
      tot_p++; flag_p += int'(err_p);
      tot_d++; flag_d += int'(err_d);
      if (i < 7) begin
        chk("R8 single flip, weighted", int'(err_h), 1);
        chk("R3 weighted syndrome", int'(syn_h), int'(ham(data8[6:0]) ^ pred_h));
        tot_h++; flag_h += int'(err_h);
      end
    end
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        data8 = base ^ (8'h01 << i) ^ (8'h01 << j);
        @(negedge clk);
        chk("R1 even-weight flip unseen by single parity", int'(err_p), 0);
        chk("R2 split parity pair flip", int'(err_d), ((i % 2) != (j % 2)) ? 1 : 0);
        tot_p++; flag_p += int'(err_p);
        tot_d++; flag_d += int'(err_d);
        if (j < 7) begin
          chk("R10 weighted pair flip", int'(err_h), 1);
          chk("R3 weighted syndrome", int'(syn_h), int'(ham(data8[6:0]) ^ pred_h));
          tot_h++; flag_h += int'(err_h);
        end
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  // bench model of the row list, built by in-place exchange
  initial begin
    int n = 0;
    for (int v = 0; v < 16; v++) if ($countones(v) >= 2) begin rows[n] = v; n++; end
    for (int p = 2; p < 12 - p; p += 2) begin
      int t = rows[p-1];
      rows[p-1] = rows[11-p];
      rows[11-p] = t;
    end
  end

  initial begin
    logic [3:0] prev;
    rst = 1'b1; data8 = 8'h01; pred_h = '0; pred_p = '0; pred_d = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset clears weighted syndrome", int'(syn_h), 0);
    chk("R7 reset clears weighted flag", int'(err_h), 0);
    chk("R7 reset clears single parity", int'(syn_p), 0);
    chk("R7 reset clears split parity", int'(syn_d), 0);
    chk("R6 pass-through ignores reset", int'(syn_c), 3);

    rst = 1'b0; data8 = 8'h00;
    @(negedge clk);
    for (int r = 0; r < 7; r++) chk("R4 bench row model", rows[r], int'(ROWTAB[r]));

    prev = 4'h0;
    for (int e = 0; e < 7; e++) begin
      data8  = {1'b0, VEC[e][14:8]};
      pred_h = VEC[e][7:4];
      #1;
      chk("R6 pass-through same cycle", int'(syn_c), int'(VEC[e][3:0]));
      chk("R6 registered holds before edge", int'(syn_h), int'(prev));
      chk("R3 model agrees with table", int'(ham(data8[6:0]) ^ pred_h), int'(VEC[e][3:0]));
      @(negedge clk);
      chk("R3 weighted syndrome from table", int'(syn_h), int'(VEC[e][3:0]));
      chk("R5 flag from table", int'(err_h), (VEC[e][3:0] != 0) ? 1 : 0);
      prev = VEC[e][3:0];
    end

    pred_h = '0;
    for (int i = 0; i < 7; i++) begin
      data8 = 8'h01 << i;
      @(negedge clk);
      chk("R4 coefficient row", int'(syn_h), int'(ROWTAB[i]));
    end

    for (int i = 0; i < 8; i++) begin
      data8  = 8'h01 << i;
      pred_p = '0; pred_d = '0;
      @(negedge clk);
      chk("R1 single parity one-hot", int'(syn_p), 1);
      chk("R2 split parity group", int'(syn_d), (i % 2 == 0) ? 1 : 2);
    end

    set_word(8'h2A);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      pred_h = ham(7'h2A) ^ (4'h1 << k);
      @(negedge clk);
      chk("R9 predicted bit flip", int'(syn_h), 1 << k);
    end
    for (int k = 0; k < 2; k++) begin
      pred_d = dbl(8'h2A) ^ (2'h1 << k);
      @(negedge clk);
      chk("R9 split predicted flip", int'(syn_d), 1 << k);
    end

    sweep(8'h00);
    sweep(8'hA5);
    sweep(8'h3C);
    $display("single parity flagged %0d of %0d corrupted words", flag_p, tot_p);
    $display("split parity flagged %0d of %0d corrupted words", flag_d, tot_d);
    $display("weighted code flagged %0d of %0d corrupted words", flag_h, tot_h);

    data8 = 8'h01; pred_h = '0;
    rst = 1'b1;
    @(negedge clk);
    chk("R7 mid-run reset", int'(syn_h), 0);
    chk("R6 pass-through during reset", int'(syn_c), 3);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 recovery after reset", int'(syn_h), 3);

    summary();
    $finish;
  end

endmodule